// File: doc/BRIEF.md
# Bus Error Capture Registers

This block keeps a record of the first failed bus transaction so that software can inspect it later. An upstream detector pulses an error strobe for one cycle. With the strobe it presents the transaction's address, data, byte enables and bus command, plus two cause flags: retry limit expired on a posted write, and master abort. If reporting is enabled and no earlier error is still pending, the block latches all of these and raises an error-pending flag. Later errors are dropped until software acknowledges the pending one.

Software reaches three 32-bit registers through a simple register port with a select, a write strobe and a combinational read path. The first is a control/status word. It holds the captured byte enables and command, the two cause flags, the pending flag and the reporting enable. The second holds the captured address and the third the captured data. Software sets or clears the enable and acknowledges a pending error by writing a one to the pending bit.

Top module: `buserr_capture`

## Requirements
- R1: Synchronous active-high reset clears the status, address and data registers. The enable and pending bits are both zero after reset.
- R2: The status word (select 0) holds the captured byte enables in bits 31:28 and the captured command in bits 27:24. Bit 10 is the retry-expired flag, bit 9 the master-abort flag, bit 8 the pending flag and bit 0 the enable. Every other bit reads zero.
- R3: Bit 0 of the status word is written by a status write. While it is zero, error strobes change no register.
- R4: When enable is one and pending is zero, an error strobe latches the address, data, byte enables, command and both cause flags, and sets pending. The new values can be read in the cycle after the strobe.
- R5: While pending is one, further error strobes are ignored, and the first error's information is kept.
- R6: A status write with bit 8 at one clears pending. Bit 8 at zero leaves it unchanged. Clearing pending leaves the captured fields as they are until the next capture.
- R7: Writes to the address register (select 1) and the data register (select 2) are ignored. Status bits 31:24, 10 and 9 cannot be written.
- R8: The read data follows the select without delay: 0 gives status, 1 gives address, 2 gives data, and 3 reads all zeros.
- R9: A strobe in the same cycle as a status write is judged on the enable and pending values from before that write. A strobe that meets a pending error together with an acknowledge is dropped, and pending ends up zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_strobe | input | 1 | One-cycle error event |
| err_retry | input | 1 | Cause: retry limit expired on posted write |
| err_mabort | input | 1 | Cause: master abort |
| err_addr | input | 32 | Address of failing transaction |
| err_data | input | 32 | Data of failing transaction |
| err_be | input | 4 | Byte enables of failing transaction |
| err_cmd | input | 4 | Bus command of failing transaction |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |

## Verification
A wrong enable or pending state shows up in the status word in the cycle after the event that should have changed it. A missed or extra capture shows as a changed or unchanged address or data value in that same cycle. A pending flag that clears when it should not lets the next strobe overwrite the captured address, so the bench reads back the address after each ignored strobe. The same-cycle cases, where a strobe meets an acknowledge or an enable change, are driven on purpose, because a wrong priority there only appears as one lost or kept capture.

// File: rtl/buserr_pkg.sv
package buserr_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BE_W   = 4;
    localparam int CMD_W  = 4;
    localparam int REG_W  = 32;
    localparam int SEL_W  = 2;

    localparam int POS_EN     = 0;
    localparam int POS_PEND   = 8;
    localparam int POS_MABORT = 9;
    localparam int POS_RETRY  = 10;
    localparam int POS_CMD_LO = 24;
    localparam int POS_BE_LO  = POS_CMD_LO + CMD_W;

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_ADDR   = 2'd1,
        SEL_DATA   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
        logic [CMD_W-1:0]  cmd;
        logic              retry;
        logic              mabort;
    } err_evt_t;

    function automatic logic [REG_W-1:0] pack_status(
        input err_evt_t held,
        input logic     pend,
        input logic     en
    );
        logic [REG_W-1:0] w;
        w = '0;
        w[POS_BE_LO +: BE_W]   = held.be;
        w[POS_CMD_LO +: CMD_W] = held.cmd;
        w[POS_RETRY]           = held.retry;
        w[POS_MABORT]          = held.mabort;
        w[POS_PEND]            = pend;
        w[POS_EN]              = en;
        return w;
    endfunction
endpackage

// File: rtl/buserr_arm.sv
module buserr_arm (
    input  logic clk,
    input  logic rst,
    input  logic err_strobe,
    input  logic wr_ctl,
    input  logic set_en,
    input  logic ack_pend,
    output logic take,
    output logic en_q,
    output logic pend_q
);
    // capture decided on pre-write state
    assign take = err_strobe && en_q && !pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (wr_ctl) begin
                en_q <= set_en;
            end
            if (take) begin
                pend_q <= 1'b1;
            end else if (wr_ctl && ack_pend) begin
                pend_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/buserr_latch.sv
module buserr_latch
    import buserr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     take,
    input  err_evt_t evt,
    output err_evt_t held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (take) begin
            held <= evt;
        end
    end
endmodule

// File: rtl/buserr_view.sv
module buserr_view
    import buserr_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  err_evt_t         held,
    input  logic             pend,
    input  logic             en,
    output logic [REG_W-1:0] rdata
);
    logic [REG_W-1:0] addr_word;
    logic [REG_W-1:0] data_word;

    generate
        if (ADDR_W >= REG_W) begin : g_addr_full
            assign addr_word = held.addr[REG_W-1:0];
        end else begin : g_addr_pad
            assign addr_word = {{(REG_W-ADDR_W){1'b0}}, held.addr};
        end
        if (DATA_W >= REG_W) begin : g_data_full
            assign data_word = held.data[REG_W-1:0];
        end else begin : g_data_pad
            assign data_word = {{(REG_W-DATA_W){1'b0}}, held.data};
        end
    endgenerate

    always_comb begin
        unique case (reg_sel_e'(sel))
            SEL_STATUS: rdata = pack_status(held, pend, en);
            SEL_ADDR:   rdata = addr_word;
            SEL_DATA:   rdata = data_word;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/buserr_capture.sv
module buserr_capture
    import buserr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              err_strobe,
    input  logic              err_retry,
    input  logic              err_mabort,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic [DATA_W-1:0] err_data,
    input  logic [BE_W-1:0]   err_be,
    input  logic [CMD_W-1:0]  err_cmd,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata
);
    logic     wr_ctl;
    logic     take;
    logic     en_q;
    logic     pend_q;
    err_evt_t evt;
    err_evt_t held;

    assign wr_ctl = reg_wr && (reg_sel_e'(reg_sel) == SEL_STATUS);

    assign evt = '{addr: err_addr, data: err_data, be: err_be,
                   cmd: err_cmd, retry: err_retry, mabort: err_mabort};

    buserr_arm i_arm (
        .clk        (clk),
        .rst        (rst),
        .err_strobe (err_strobe),
        .wr_ctl     (wr_ctl),
        .set_en     (reg_wdata[POS_EN]),
        .ack_pend   (reg_wdata[POS_PEND]),
        .take       (take),
        .en_q       (en_q),
        .pend_q     (pend_q)
    );

    buserr_latch i_latch (
        .clk  (clk),
        .rst  (rst),
        .take (take),
        .evt  (evt),
        .held (held)
    );

    buserr_view i_view (
        .sel   (reg_sel),
        .held  (held),
        .pend  (pend_q),
        .en    (en_q),
        .rdata (reg_rdata)
    );
endmodule

// File: rtl/buserr_capture_chk.sv
module buserr_capture_chk
    import buserr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              err_strobe,
    input logic              wr_ctl,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [SEL_W-1:0]  reg_sel,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              en_q,
    input logic              pend_q,
    input err_evt_t          held
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!en_q && !pend_q && held == '0));

    // R4
    rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(err_strobe && en_q));

    // R3
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !pend_q) |=> !pend_q);

    // R5
    held_kept_chk: assert property (@(posedge clk) disable iff (rst)
        pend_q |=> $stable(held));

    // R6
    ack_zero_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !(wr_ctl && reg_wdata[POS_PEND])) |=> pend_q);

    // R8
    unused_sel_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == SEL_NONE) |-> (reg_rdata == '0));
endmodule

bind buserr_capture buserr_capture_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .err_strobe (err_strobe),
    .wr_ctl     (wr_ctl),
    .reg_wdata  (reg_wdata),
    .reg_sel    (reg_sel),
    .reg_rdata  (reg_rdata),
    .en_q       (en_q),
    .pend_q     (pend_q),
    .held       (held)
);

// File: tb/test_buserr_capture.sv
module test_buserr_capture;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        err_strobe = 1'b0;
    logic        err_retry = 1'b0;
    logic        err_mabort = 1'b0;
    logic [31:0] err_addr = '0;
    logic [31:0] err_data = '0;
    logic [3:0]  err_be = '0;
    logic [3:0]  err_cmd = '0;
    logic [1:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    buserr_capture i_buserr_capture (
        .clk(clk), .rst(rst), .err_strobe(err_strobe), .err_retry(err_retry),
        .err_mabort(err_mabort), .err_addr(err_addr), .err_data(err_data),
        .err_be(err_be), .err_cmd(err_cmd), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    typedef struct packed {
        logic [1:0]  act;   // bit0 write, bit1 strobe
        logic [1:0]  sel;   // write target and read-back select
        logic [31:0] a;     // strobe address or write data
        logic [31:0] d;
        logic [3:0]  be;
        logic [3:0]  cmd;
        logic        rt;
        logic        ma;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VT [NV] = '{
        '{2'd0, 2'd0, 32'h0, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 32'h0, 4'd1},               // R1
        '{2'd2, 2'd1, 32'h0000_0AAA, 32'h1, 4'h1, 4'h1, 1'b1, 1'b1, 32'h0, 4'd3},      // R3
        '{2'd0, 2'd0, 32'h0, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 32'h0, 4'd3},
        '{2'd1, 2'd0, 32'h0000_0001, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 32'h1, 4'd3},
        '{2'd1, 2'd0, 32'hFFFF_FFFF, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 32'h1, 4'd7},      // R7
        '{2'd2, 2'd0, 32'h1234_5678, 32'hDEAD_BEEF, 4'hA, 4'h7, 1'b1, 1'b0, 32'hA700_0501, 4'd2}, // R2 R4
        '{2'd0, 2'd1, 32'h0, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 32'h1234_5678, 4'd4},
        '{2'd0, 2'd2, 32'h0, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 32'hDEAD_BEEF, 4'd4},
        '{2'd2, 2'd1, 32'h0BAD_0000, 32'h1, 4'h3, 4'h2, 1'b0, 1'b1, 32'h1234_5678, 4'd5}, // R5
        '{2'd0, 2'd0, 32'h0, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 32'hA700_0501, 4'd5},
        '{2'd1, 2'd0, 32'h0000_0001, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 32'hA700_0501, 4'd6}, // R6
        '{2'd1, 2'd0, 32'h0000_0101, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 32'hA700_0401, 4'd6},
        '{2'd1, 2'd1, 32'hFFFF_FFFF, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 32'h1234_5678, 4'd7},
        '{2'd2, 2'd0, 32'h0BAD_0004, 32'h5555_AAAA, 4'hF, 4'h6, 1'b0, 1'b1, 32'hF600_0301, 4'd4},
        '{2'd1, 2'd2, 32'h0, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 32'h5555_AAAA, 4'd7},
        '{2'd0, 2'd3, 32'h0, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 32'h0, 4'd8},              // R8
        '{2'd1, 2'd0, 32'h0000_0100, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 32'hF600_0200, 4'd6}
    };

    task automatic chk(input int req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [1:0] wsel, input logic [31:0] wd,
                        input logic stb, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be, input logic [3:0] cmd, input logic rt,
                        input logic ma, input logic [1:0] rsel);
        @(negedge clk);
        reg_wr = wr; reg_sel = wsel; reg_wdata = wd;
        err_strobe = stb; err_addr = a; err_data = d; err_be = be;
        err_cmd = cmd; err_retry = rt; err_mabort = ma;
        @(negedge clk);
        reg_wr = 1'b0; err_strobe = 1'b0; reg_sel = rsel;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            step(VT[i].act[0], VT[i].sel, VT[i].a, VT[i].act[1], VT[i].a, VT[i].d,
                 VT[i].be, VT[i].cmd, VT[i].rt, VT[i].ma, VT[i].sel);
            chk(int'(VT[i].req), reg_rdata, VT[i].exp);
        end

        // R9: strobe meets acknowledge while pending
        step(1'b1, 2'd0, 32'h1, 1'b0, 0, 0, 0, 0, 0, 0, 2'd0);
        step(1'b0, 2'd0, 0, 1'b1, 32'h100, 32'h11, 4'h1, 4'h1, 1'b0, 1'b0, 2'd0);
        chk(4, reg_rdata, 32'h1100_0101);
        step(1'b1, 2'd0, 32'h101, 1'b1, 32'h200, 32'h22, 4'h2, 4'h2, 1'b1, 1'b1, 2'd0);
        chk(9, reg_rdata, 32'h1100_0001);
        reg_sel = 2'd1; #1;
        chk(9, reg_rdata, 32'h100);
        // R4: re-armed capture
        step(1'b0, 2'd0, 0, 1'b1, 32'h300, 32'h33, 4'h3, 4'h3, 1'b0, 1'b0, 2'd1);
        chk(4, reg_rdata, 32'h300);
        // R9: enable written in the strobe cycle does not apply yet
        step(1'b1, 2'd0, 32'h100, 1'b0, 0, 0, 0, 0, 0, 0, 2'd0);
        step(1'b1, 2'd0, 32'h1, 1'b1, 32'h400, 32'h44, 4'h4, 4'h4, 1'b0, 1'b0, 2'd0);
        chk(9, reg_rdata, 32'h3300_0001);
        reg_sel = 2'd1; #1;
        chk(9, reg_rdata, 32'h300);

        // R1: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        for (int s = 0; s < 3; s++) begin
            reg_sel = 2'(s); #1;
            chk(1, reg_rdata, 32'h0);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule